// File: doc/BRIEF.md
# Programmable Device Configuration Sequencer

This controller takes a programmable device from power-up to user operation through four phases: initialization, configuration, start-up and operation. While initializing, it pulls the shared open-drain INIT line low and asks for the configuration memory to be zeroed. It then waits until the wired-AND INIT line has read high long enough. In configuration it counts configuration clock ticks against a length value taken from the bitstream. Once both the count and the end frame are in, it enables the I/Os, releases the internal reset and raises DONE.

The line that reads INIT and the active-low RESET and PRGM inputs are asynchronous. Each passes through a two-stage synchronizer before the state machine sees it. The rest of the inputs are treated as synchronous to `clk`. The configuration clock arrives as a one-cycle tick. The memory clear is a request/acknowledge handshake. Every output is a register loaded from the next-phase decode, so every output changes on the same edge as `phase_o`.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `por_rst` is high at a clock edge, that edge forces the clear phase (`phase_o` = 0). In that phase `init_pull_o`=1, `hdc_o`=1, `ldc_o`=0, `done_o`=0, `io_en_o`=0 and `int_rst_rel_o`=0. The phase codes are 0 clear, 1 wait-for-INIT, 2 load, 3 start-up and 4 run.
- R2: In the clear phase, with the skip option not in effect, `mem_clr_req_o` stays high until `mem_clr_ack_i` is seen at a clock edge. That edge moves to phase 1, where `init_pull_o` and `mem_clr_req_o` are 0.
- R3: Once a configuration has completed (start-up reached), a later re-entry to the clear phase with `skip_clear_i`=1 raises no clear request and leaves for phase 1 at the next edge.
- R4: In phase 1, the phase does not change while the synchronized INIT line reads low.
- R5: With `master_i`=0, and synchronized RESET and PRGM already high in phase 1, a rise of `init_line_i` makes phase 2 appear on the fourth clock edge after the rise. That is two synchronizer stages plus two qualifying cycles.
- R6: With `master_i`=1, the same entry takes six further cycles, so phase 2 appears on the tenth edge after the rise.
- R7: `mode_i` is captured into `mode_o` on the edge that enters phase 2, and `mode_o` holds that value while the phase stays at 2.
- R8: A tick counter clears on entry to phase 2 and counts `cclk_en_i` ticks. Phase 3 is entered only on the edge after both of these hold: the count equals `len_i`, and an `end_frame_i` strobe has been seen. A matching count alone does not leave phase 2.
- R9: In phase 2, a low RESET or PRGM (after synchronization) returns the phase to 0. Phase 2 is not entered again while either one is still low.
- R10: `bit_err_i` high at an edge in phase 2 returns the phase to 0 at that edge.
- R11: Phase 3 lasts one cycle and is followed by phase 4. In phases 3 and 4, `done_o`, `io_en_o` and `int_rst_rel_o` are 1, `hdc_o` is 0 and `ldc_o` is 1.
- R12: In phases 3 and 4, a low RESET has no effect on the phase, while a low PRGM (after synchronization) returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| init_line_i | input | 1 | Level read back from the wired-AND INIT line (asynchronous) |
| reset_n_i | input | 1 | Active-low reset request (asynchronous) |
| prgm_n_i | input | 1 | Active-low reprogram request (asynchronous) |
| master_i | input | 1 | 1 when this device sources the configuration clock |
| mode_i | input | MODE_W | Mode select lines |
| skip_clear_i | input | 1 | Option: reconfigure without clearing memory |
| len_i | input | CNT_W | Length count loaded from the bitstream |
| cclk_en_i | input | 1 | One-cycle configuration clock tick |
| end_frame_i | input | 1 | End-of-configuration frame written |
| bit_err_i | input | 1 | Bitstream error flag |
| mem_clr_ack_i | input | 1 | Configuration memory clear finished |
| init_pull_o | output | 1 | Enable for the INIT pull-down |
| hdc_o | output | 1 | High during initialization and configuration |
| ldc_o | output | 1 | Low during initialization and configuration |
| done_o | output | 1 | Configuration done |
| io_en_o | output | 1 | User I/O enable |
| int_rst_rel_o | output | 1 | Internal reset release |
| mem_clr_req_o | output | 1 | Configuration memory clear request |
| mode_o | output | MODE_W | Mode captured on entry to configuration |
| phase_o | output | 3 | Current phase code |

## Verification
The hardest condition to reach is the gated re-entry into configuration. The controller must sit in the wait phase with INIT already high while RESET or PRGM is still held low, and only advance once that pin rises. The stimulus gets there after an abort: it holds the pin low, acknowledges the clear and raises INIT. It lets the wait phase run well past the qualifying window, then releases the pin and counts the edges to entry. The skip-clear path needs a full completed configuration first, so it comes at the end of a sequence that also exercises the master-mode delay.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    PH_CLEAR = 3'd0,
    PH_WAIT  = 3'd1,
    PH_LOAD  = 3'd2,
    PH_START = 3'd3,
    PH_RUN   = 3'd4
  } phase_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_qual.sv
module cfg_qual #(
  parameter int QUAL_CYC     = 2,
  parameter int MASTER_EXTRA = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ok_i,
  input  logic master_i,
  output logic hit_o
);
  localparam int TOTAL = QUAL_CYC + MASTER_EXTRA;
  localparam int QW    = $clog2(TOTAL + 1);

  logic [QW-1:0] run_q;
  logic [QW-1:0] need_m1;

  assign need_m1 = master_i ? QW'(TOTAL - 1) : QW'(QUAL_CYC - 1);
  assign hit_o   = en_i && ok_i && (run_q == need_m1);

  always_ff @(posedge clk) begin
    if (rst)                        run_q <= '0;
    else if (en_i && ok_i && !hit_o) run_q <= run_q + 1'b1;
    else                            run_q <= '0;
  end
endmodule

// File: rtl/cfg_len_cnt.sv
module cfg_len_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             frame_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] ticks_q;
  logic             frame_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      ticks_q <= '0;
      frame_q <= 1'b0;
    end else begin
      if (tick_i && ticks_q != CNT_MAX) ticks_q <= ticks_q + 1'b1;
      if (frame_i)                      frame_q <= 1'b1;
    end
  end

  assign match_o = frame_q && (ticks_q == len_i);
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W       = 4,
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_CYC     = 2,
  parameter int MASTER_EXTRA = 6
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              init_line_i,
  input  logic              reset_n_i,
  input  logic              prgm_n_i,
  input  logic              master_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              skip_clear_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              cclk_en_i,
  input  logic              end_frame_i,
  input  logic              bit_err_i,
  input  logic              mem_clr_ack_i,
  output logic              init_pull_o,
  output logic              hdc_o,
  output logic              ldc_o,
  output logic              done_o,
  output logic              io_en_o,
  output logic              int_rst_rel_o,
  output logic              mem_clr_req_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [2:0]        phase_o
);
  localparam int NSYNC = 3;

  phase_e           ph_q, ph_nxt;
  logic [NSYNC-1:0] raw_v, sync_v;
  logic             init_s, rstn_s, prgn_s;
  logic             pins_ok, qual_hit, load_done;
  logic             configured_q, skip_eff;

  assign raw_v = {prgm_n_i, reset_n_i, init_line_i};

  cfg_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (por_rst),
    .d_i (raw_v),
    .q_o (sync_v)
  );

  assign init_s  = sync_v[0];
  assign rstn_s  = sync_v[1];
  assign prgn_s  = sync_v[2];
  assign pins_ok = init_s && rstn_s && prgn_s;

  cfg_qual #(.QUAL_CYC(QUAL_CYC), .MASTER_EXTRA(MASTER_EXTRA)) u_qual (
    .clk      (clk),
    .rst      (por_rst),
    .en_i     (ph_q == PH_WAIT),
    .ok_i     (pins_ok),
    .master_i (master_i),
    .hit_o    (qual_hit)
  );

  cfg_len_cnt #(.CNT_W(CNT_W)) u_len (
    .clk      (clk),
    .rst      (por_rst),
    .active_i (ph_q == PH_LOAD),
    .tick_i   (cclk_en_i),
    .frame_i  (end_frame_i),
    .len_i    (len_i),
    .match_o  (load_done)
  );

  assign skip_eff = skip_clear_i && configured_q;

  always_comb begin
    ph_nxt = ph_q;
    unique case (ph_q)
      PH_CLEAR: if (skip_eff || mem_clr_ack_i) ph_nxt = PH_WAIT;
      PH_WAIT:  if (qual_hit) ph_nxt = PH_LOAD;
      PH_LOAD: begin
        if (!rstn_s || !prgn_s || bit_err_i) ph_nxt = PH_CLEAR;
        else if (load_done)                  ph_nxt = PH_START;
      end
      PH_START: ph_nxt = prgn_s ? PH_RUN : PH_CLEAR;
      PH_RUN:   if (!prgn_s) ph_nxt = PH_CLEAR;
      default:  ph_nxt = PH_CLEAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      ph_q          <= PH_CLEAR;
      configured_q  <= 1'b0;
      mode_o        <= '0;
      init_pull_o   <= 1'b1;
      hdc_o         <= 1'b1;
      ldc_o         <= 1'b0;
      done_o        <= 1'b0;
      io_en_o       <= 1'b0;
      int_rst_rel_o <= 1'b0;
      mem_clr_req_o <= 1'b1;
    end else begin
      ph_q <= ph_nxt;
      if (ph_q == PH_START) configured_q <= 1'b1;
      if (ph_q == PH_WAIT && ph_nxt == PH_LOAD) mode_o <= mode_i;
      init_pull_o   <= (ph_nxt == PH_CLEAR);
      hdc_o         <= (ph_nxt == PH_CLEAR) || (ph_nxt == PH_WAIT) || (ph_nxt == PH_LOAD);
      ldc_o         <= (ph_nxt == PH_START) || (ph_nxt == PH_RUN);
      done_o        <= (ph_nxt == PH_START) || (ph_nxt == PH_RUN);
      io_en_o       <= (ph_nxt == PH_START) || (ph_nxt == PH_RUN);
      int_rst_rel_o <= (ph_nxt == PH_START) || (ph_nxt == PH_RUN);
      mem_clr_req_o <= (ph_nxt == PH_CLEAR) && !skip_eff;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              por_rst,
  input logic [2:0]        phase_o,
  input logic              init_s,
  input logic              rstn_s,
  input logic              prgn_s,
  input logic              bit_err_i,
  input logic              mem_clr_ack_i,
  input logic              skip_clear_i,
  input logic              mem_clr_req_o,
  input logic              hdc_o,
  input logic              ldc_o,
  input logic              done_o,
  input logic              io_en_o,
  input logic              int_rst_rel_o,
  input logic [MODE_W-1:0] mode_o
);
  p_hdc_ldc_r1: assert property (@(posedge clk) disable iff (por_rst)
    hdc_o != ldc_o);

  p_req_held_r2: assert property (@(posedge clk) disable iff (por_rst)
    (mem_clr_req_o && !mem_clr_ack_i && !skip_clear_i) |=> (phase_o == 3'd0));

  p_init_hold_r4: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd1 && !init_s) |=> (phase_o == 3'd1));

  p_load_from_wait_r5: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd2 && $past(phase_o) != 3'd2) |-> ($past(phase_o) == 3'd1));

  p_mode_stable_r7: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd2 && $past(phase_o) == 3'd2) |-> $stable(mode_o));

  p_abort_pin_r9: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd2 && (!rstn_s || !prgn_s)) |=> (phase_o == 3'd0));

  p_abort_err_r10: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd2 && bit_err_i) |=> (phase_o == 3'd0));

  p_start_one_cycle_r11: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd3 && prgn_s) |=> (phase_o == 3'd4));

  p_done_group_r11: assert property (@(posedge clk) disable iff (por_rst)
    done_o |-> (io_en_o && int_rst_rel_o && phase_o >= 3'd3));

  p_run_holds_r12: assert property (@(posedge clk) disable iff (por_rst)
    (phase_o == 3'd4 && prgn_s) |=> (phase_o == 3'd4));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk           (clk),
  .por_rst       (por_rst),
  .phase_o       (phase_o),
  .init_s        (init_s),
  .rstn_s        (rstn_s),
  .prgn_s        (prgn_s),
  .bit_err_i     (bit_err_i),
  .mem_clr_ack_i (mem_clr_ack_i),
  .skip_clear_i  (skip_clear_i),
  .mem_clr_req_o (mem_clr_req_o),
  .hdc_o         (hdc_o),
  .ldc_o         (ldc_o),
  .done_o        (done_o),
  .io_en_o       (io_en_o),
  .int_rst_rel_o (int_rst_rel_o),
  .mode_o        (mode_o)
);

// File: tb/cfg_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_tb_top;
  localparam int MODE_W = 4;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              por_rst = 1'b1;
  logic              init_line_i = 1'b0, reset_n_i = 1'b1, prgm_n_i = 1'b1;
  logic              master_i = 1'b0, skip_clear_i = 1'b0;
  logic [MODE_W-1:0] mode_i = '0;
  logic [CNT_W-1:0]  len_i = 16'd5;
  logic              cclk_en_i = 1'b0, end_frame_i = 1'b0, bit_err_i = 1'b0, mem_clr_ack_i = 1'b0;
  logic              init_pull_o, hdc_o, ldc_o, done_o, io_en_o, int_rst_rel_o, mem_clr_req_o;
  logic [MODE_W-1:0] mode_o;
  logic [2:0]        phase_o;

  always #4 clk = ~clk;

  cfg_seq_ctrl #(.MODE_W(MODE_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .por_rst(por_rst), .init_line_i(init_line_i), .reset_n_i(reset_n_i),
    .prgm_n_i(prgm_n_i), .master_i(master_i), .mode_i(mode_i), .skip_clear_i(skip_clear_i),
    .len_i(len_i), .cclk_en_i(cclk_en_i), .end_frame_i(end_frame_i), .bit_err_i(bit_err_i),
    .mem_clr_ack_i(mem_clr_ack_i), .init_pull_o(init_pull_o), .hdc_o(hdc_o), .ldc_o(ldc_o),
    .done_o(done_o), .io_en_o(io_en_o), .int_rst_rel_o(int_rst_rel_o),
    .mem_clr_req_o(mem_clr_req_o), .mode_o(mode_o), .phase_o(phase_o)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R1";
  bit    cmp_en = 0;
  bit    finished = 0;

  // behavioural reference model
  int m_st, m_hi, m_cnt, m_eof, m_cfgd, m_mode, m_req;
  int q_init[$], q_rst[$], q_prg[$];

  always @(posedge clk) begin
    if (por_rst) begin
      m_st = 0; m_hi = 0; m_cnt = 0; m_eof = 0; m_cfgd = 0; m_mode = 0; m_req = 1;
      q_init = '{0, 0}; q_rst = '{0, 0}; q_prg = '{0, 0};
    end else begin
      int si, sr, sp, need, nst;
      bit ok, hit;
      si = q_init[0]; sr = q_rst[0]; sp = q_prg[0];
      ok = (si == 1) && (sr == 1) && (sp == 1);
      need = master_i ? 8 : 2;
      hit = (m_st == 1) && ok && (m_hi == need - 1);
      nst = m_st;
      case (m_st)
        0: if ((skip_clear_i && m_cfgd == 1) || mem_clr_ack_i) nst = 1;
        1: if (hit) nst = 2;
        2: if (sr == 0 || sp == 0 || bit_err_i) nst = 0;
           else if (m_cnt == int'(len_i) && m_eof == 1) nst = 3;
        3: nst = (sp == 1) ? 4 : 0;
        4: if (sp == 0) nst = 0;
        default: nst = 0;
      endcase
      m_req = (nst == 0 && !(skip_clear_i && m_cfgd == 1)) ? 1 : 0;
      if (m_st == 1 && nst == 2) m_mode = int'(mode_i);
      m_hi = (m_st == 1 && ok && !hit) ? m_hi + 1 : 0;
      if (m_st != 2) begin m_cnt = 0; m_eof = 0; end
      else begin
        if (cclk_en_i && m_cnt < 65535) m_cnt++;
        if (end_frame_i) m_eof = 1;
      end
      if (m_st == 3) m_cfgd = 1;
      void'(q_init.pop_front()); q_init.push_back(int'(init_line_i));
      void'(q_rst.pop_front());  q_rst.push_back(int'(reset_n_i));
      void'(q_prg.pop_front());  q_prg.push_back(int'(prgm_n_i));
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      int eh, ed;
      eh = (m_st <= 2) ? 1 : 0;
      ed = (m_st >= 3) ? 1 : 0;
      n_chk++;
      if (int'(phase_o) != m_st || int'(init_pull_o) != (m_st == 0 ? 1 : 0) ||
          int'(hdc_o) != eh || int'(ldc_o) != 1 - eh || int'(done_o) != ed ||
          int'(io_en_o) != ed || int'(int_rst_rel_o) != ed ||
          int'(mem_clr_req_o) != m_req || int'(mode_o) != m_mode) begin
        n_fail++;
        $display("FAIL %s model: phase=%0d pull=%0d hdc=%0d done=%0d req=%0d mode=%0d expected phase=%0d pull=%0d hdc=%0d done=%0d req=%0d mode=%0d",
                 cur_tag, phase_o, init_pull_o, hdc_o, done_o, mem_clr_req_o, mode_o,
                 m_st, (m_st == 0), eh, ed, m_req, m_mode);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_phase(input string tag, input int p, input int max);
    int k = 0;
    while (int'(phase_o) != p && k < max) begin @(negedge clk); k++; end
    check(tag, int'(phase_o), p);
  endtask

  task automatic pulse_ack();
    @(negedge clk) mem_clr_ack_i = 1'b1;
    @(negedge clk) mem_clr_ack_i = 1'b0;
  endtask

  task automatic count_entry(input string tag, input int exp);
    int k = 0;
    @(negedge clk) init_line_i = 1'b1;
    while (int'(phase_o) != 2 && k < 40) begin @(negedge clk); k++; end
    check(tag, k, exp);
  endtask

  task automatic finish_load();
    @(negedge clk) cclk_en_i = 1'b1;
    cyc(5);
    cclk_en_i = 1'b0;
    cyc(4);
    check("R8 count match without end frame stays in load", int'(phase_o), 2);
    end_frame_i = 1'b1;
    @(negedge clk) end_frame_i = 1'b0;
    check("R8 end frame seen, still one edge to go", int'(phase_o), 2);
    @(negedge clk);
    check("R11 start-up entered", int'(phase_o), 3);
    check("R11 done in start-up", int'(done_o), 1);
    @(negedge clk);
    check("R11 run follows start-up", int'(phase_o), 4);
    check("R11 io enable", int'(io_en_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in %s actual=hung expected=finished", cur_tag);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    cmp_en = 1;
    por_rst = 1'b0;
    // R1 reset state
    cur_tag = "R1";
    check("R1 phase after reset", int'(phase_o), 0);
    check("R1 INIT pulled low", int'(init_pull_o), 1);
    check("R1 hdc high", int'(hdc_o), 1);
    check("R1 ldc low", int'(ldc_o), 0);
    check("R1 done low", int'(done_o), 0);
    // R2 clear handshake
    cur_tag = "R2";
    cyc(6);
    check("R2 request held without ack", int'(mem_clr_req_o), 1);
    check("R2 still clearing", int'(phase_o), 0);
    pulse_ack();
    check("R2 wait phase after ack", int'(phase_o), 1);
    check("R2 INIT released", int'(init_pull_o), 0);
    check("R2 request dropped", int'(mem_clr_req_o), 0);
    // R4 INIT line held low
    cur_tag = "R4";
    cyc(12);
    check("R4 held in wait while INIT low", int'(phase_o), 1);
    // R5 slave entry, R7 mode capture
    cur_tag = "R5";
    mode_i = 4'hA;
    count_entry("R5 slave entry edge count", 4);
    cur_tag = "R7";
    check("R7 mode captured", int'(mode_o), 10);
    mode_i = 4'h3;
    cyc(2);
    check("R7 mode held in load", int'(mode_o), 10);
    cur_tag = "R8";
    finish_load();
    // R12 RESET ignored in run, PRGM returns
    cur_tag = "R12";
    reset_n_i = 1'b0;
    cyc(8);
    check("R12 RESET ignored in run", int'(phase_o), 4);
    reset_n_i = 1'b1;
    cyc(3);
    prgm_n_i = 1'b0;
    wait_phase("R12 PRGM low returns to clear", 0, 6);
    check("R12 clear requested again", int'(mem_clr_req_o), 1);
    // R9 pin still low blocks re-entry
    cur_tag = "R9";
    pulse_ack();
    cyc(12);
    check("R9 no load while PRGM low", int'(phase_o), 1);
    prgm_n_i = 1'b1;
    wait_phase("R9 load after PRGM high", 2, 8);
    reset_n_i = 1'b0;
    wait_phase("R9 RESET aborts load", 0, 6);
    pulse_ack();
    cyc(12);
    check("R9 no load while RESET low", int'(phase_o), 1);
    reset_n_i = 1'b1;
    wait_phase("R9 load after RESET high", 2, 8);
    // R10 bit error
    cur_tag = "R10";
    @(negedge clk) bit_err_i = 1'b1;
    @(negedge clk) bit_err_i = 1'b0;
    check("R10 bit error aborts", int'(phase_o), 0);
    // R6 master mode
    cur_tag = "R6";
    init_line_i = 1'b0;
    master_i = 1'b1;
    pulse_ack();
    cyc(8);
    check("R6 waiting in master mode", int'(phase_o), 1);
    count_entry("R6 master entry edge count", 10);
    cur_tag = "R8";
    finish_load();
    // R3 skip clear on reconfiguration
    cur_tag = "R3";
    skip_clear_i = 1'b1;
    prgm_n_i = 1'b0;
    wait_phase("R3 back to clear", 0, 6);
    check("R3 no clear request", int'(mem_clr_req_o), 0);
    @(negedge clk);
    check("R3 leaves clear without ack", int'(phase_o), 1);
    prgm_n_i = 1'b1;
    cyc(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule